// File: doc/BRIEF.md
# Multi-Slope Integration Timing Generator

This block produces the per-frame pixel control timing for a line-scanned image sensor. Time is counted in row periods. A row period is the row overhead time plus the number of pixels read multiplied by the clock period. A row-tick input marks the end of each row period, and a frame-start input opens a new integration frame.

Within a frame the block drives four signals. The first is a main pixel reset level. The second and third are optional extra reset pulses for dual-slope and triple-slope wide-dynamic-range integration. The fourth is a frame-transfer strobe that moves charge to the storage node and ends integration.

Every event sits on a row-count grid with an offset of minus one: a position value `p` places its event in row `p-1`. The block samples all configuration inputs at frame start. A change made while a frame is running therefore takes effect only in the next frame.

Top module: `slope_timing_gen`

## Requirements
- R1: After reset, and until the first frame start, all four outputs are 0, even when row ticks arrive.
- R2: A frame start sets the row count to 0 on that clock edge. Each later clock edge with the row tick high and frame start low adds one to the row count. An output changes only on an edge that carries a frame start or a row tick.
- R3: `pix_reset_o` is 1 in rows 0 through `rst_len_i-2`, so it stays high for `rst_len_i-1` row periods. A length below 2 acts as 2.
- R4: When `ds_en_i` is 1, `ds_reset_o` is 1 in row `ds_pos_i-1` only. A position of 0 never fires.
- R5: When `ts_en_i` is 1, `ts_reset_o` is 1 in row `ts_pos_i-1` only. A position of 0 never fires.
- R6: `xfer_o` is 1 in row `xfer_pos_i-1` only, for exactly one row period. A position of 0 never fires.
- R7: When a slope enable is 0, its position input is ignored and its pulse output stays 0 for the whole frame.
- R8: When `ndr_en_i` is 1, `pix_reset_o` stays 0 for the whole frame, and the other events are unaffected.
- R9: All configuration inputs are captured at frame start. A change made mid-frame has no effect until the next frame start.
- R10: The row count saturates at 4095 and does not wrap, so no event repeats within a frame however many row ticks arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | Starts a frame: clears the row count and captures the configuration |
| line_tick_i | input | 1 | One-cycle marker at the end of each row period |
| rst_len_i | input | 12 | Main reset length, in rows plus one (minimum 2) |
| ds_en_i | input | 1 | Dual-slope extra reset enable |
| ds_pos_i | input | 12 | Dual-slope pulse position, in rows plus one |
| ts_en_i | input | 1 | Triple-slope extra reset enable |
| ts_pos_i | input | 12 | Triple-slope pulse position, in rows plus one |
| xfer_pos_i | input | 12 | Frame-transfer position, in rows plus one |
| ndr_en_i | input | 1 | Non-destructive readout: suppresses the main reset |
| pix_reset_o | output | 1 | Main pixel reset level |
| ds_reset_o | output | 1 | Dual-slope extra reset pulse |
| ts_reset_o | output | 1 | Triple-slope extra reset pulse |
| xfer_o | output | 1 | Frame-transfer strobe |

## Verification
The assertions check several properties on every cycle. The row count steps by exactly one per tick, clears on frame start and holds at saturation. The captured configuration stays frozen between frame starts. Outputs stay silent before the first frame, pulses start only on a row boundary, and the transfer strobe drops after one row.

The directed scenarios show what the assertions cannot. They check that each pulse lands in the right row for a given position. They also cover the clamp on short reset lengths, the effect of the enable and non-destructive bits, a mid-frame change that is deferred, and the absence of a repeat after the count saturates.

// File: rtl/slope_timing_pkg.sv
package slope_timing_pkg;
  localparam int ROW_W   = 12;
  localparam int NUM_EVT = 3;  // 0: dual slope, 1: triple slope, 2: frame transfer
  localparam int EVT_DS  = 0;
  localparam int EVT_TS  = 1;
  localparam int EVT_FT  = 2;
  localparam int MIN_LEN = 2;

  typedef logic [ROW_W-1:0] row_t;

  typedef struct packed {
    row_t                   rst_len;
    logic                   ndr;
    logic [NUM_EVT-1:0]     evt_en;
    row_t [NUM_EVT-1:0]     evt_pos;
  } cfg_t;
endpackage

// File: rtl/stg_row_counter.sv
module stg_row_counter
  import slope_timing_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_start_i,
  input  logic line_tick_i,
  output row_t row_o,
  output logic active_o
);
  localparam row_t ROW_MAX = {ROW_W{1'b1}};

  row_t cnt_q;
  logic active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (frame_start_i) begin
      cnt_q    <= '0;
      active_q <= 1'b1;
    end else if (line_tick_i && cnt_q != ROW_MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign row_o    = cnt_q;
  assign active_o = active_q;

  assert_row_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_tick_i && !frame_start_i && cnt_q != ROW_MAX |=> cnt_q == $past(cnt_q) + 1'b1);
  assert_row_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> cnt_q == '0 && active_q);
  assert_row_sat_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q == ROW_MAX && !frame_start_i |=> cnt_q == ROW_MAX);
endmodule

// File: rtl/stg_cfg_shadow.sv
module stg_cfg_shadow
  import slope_timing_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_start_i,
  input  cfg_t cfg_i,
  output cfg_t cfg_o
);
  cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q         <= '0;
      cfg_q.rst_len <= row_t'(MIN_LEN);
    end else if (frame_start_i) begin
      cfg_q <= cfg_i;
      // lengths below the legal minimum act as the minimum
      if (cfg_i.rst_len < row_t'(MIN_LEN)) cfg_q.rst_len <= row_t'(MIN_LEN);
    end
  end

  assign cfg_o = cfg_q;

  assert_cfg_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i |=> $stable(cfg_q));
  assert_cfg_len_min_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.rst_len >= row_t'(MIN_LEN));
endmodule

// File: rtl/stg_event_dec.sv
module stg_event_dec
  import slope_timing_pkg::*;
(
  input  row_t row_i,
  input  logic active_i,
  input  logic en_i,
  input  row_t pos_i,
  output logic hit_o
);
  // position p fires in row p-1; p == 0 never fires
  assign hit_o = active_i && en_i && (pos_i != '0) && (row_i == pos_i - 1'b1);
endmodule

// File: rtl/slope_timing_gen.sv
module slope_timing_gen
  import slope_timing_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_start_i,
  input  logic             line_tick_i,
  input  logic [ROW_W-1:0] rst_len_i,
  input  logic             ds_en_i,
  input  logic [ROW_W-1:0] ds_pos_i,
  input  logic             ts_en_i,
  input  logic [ROW_W-1:0] ts_pos_i,
  input  logic [ROW_W-1:0] xfer_pos_i,
  input  logic             ndr_en_i,
  output logic             pix_reset_o,
  output logic             ds_reset_o,
  output logic             ts_reset_o,
  output logic             xfer_o
);
  cfg_t cfg_in, cfg_q;
  row_t row;
  logic active;
  logic [NUM_EVT-1:0] hit;

  always_comb begin
    cfg_in                 = '0;
    cfg_in.rst_len         = rst_len_i;
    cfg_in.ndr             = ndr_en_i;
    cfg_in.evt_en[EVT_DS]  = ds_en_i;
    cfg_in.evt_en[EVT_TS]  = ts_en_i;
    cfg_in.evt_en[EVT_FT]  = 1'b1;
    cfg_in.evt_pos[EVT_DS] = ds_pos_i;
    cfg_in.evt_pos[EVT_TS] = ts_pos_i;
    cfg_in.evt_pos[EVT_FT] = xfer_pos_i;
  end

  stg_cfg_shadow u_shadow (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .frame_start_i (frame_start_i),
    .cfg_i         (cfg_in),
    .cfg_o         (cfg_q)
  );

  stg_row_counter u_rows (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .frame_start_i (frame_start_i),
    .line_tick_i   (line_tick_i),
    .row_o         (row),
    .active_o      (active)
  );

  for (genvar e = 0; e < NUM_EVT; e++) begin : g_evt
    stg_event_dec u_dec (
      .row_i    (row),
      .active_i (active),
      .en_i     (cfg_q.evt_en[e]),
      .pos_i    (cfg_q.evt_pos[e]),
      .hit_o    (hit[e])
    );
  end

  assign pix_reset_o = active && !cfg_q.ndr && (row < cfg_q.rst_len - 1'b1);
  assign ds_reset_o  = hit[EVT_DS];
  assign ts_reset_o  = hit[EVT_TS];
  assign xfer_o      = hit[EVT_FT];

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |-> !(pix_reset_o || ds_reset_o || ts_reset_o || xfer_o));
  assert_evt_on_boundary_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ds_reset_o) || $rose(ts_reset_o) || $rose(xfer_o)
      |-> $past(line_tick_i) || $past(frame_start_i));
  assert_xfer_one_row_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_o && line_tick_i && !frame_start_i |=> !xfer_o);
  assert_out_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_tick_i && !frame_start_i
      |=> $stable({pix_reset_o, ds_reset_o, ts_reset_o, xfer_o}));
endmodule

// File: tb/slope_timing_gen_tb.sv
module slope_timing_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ROW_MAX = 4095;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic frame_start = 1'b0, line_tick = 1'b0;
  logic [11:0] rst_len = 12'd2, ds_pos = '0, ts_pos = '0, xfer_pos = '0;
  logic ds_en = 1'b0, ts_en = 1'b0, ndr_en = 1'b0;
  logic pix_reset, ds_reset, ts_reset, xfer;

  int n_checks = 0, n_fail = 0;
  // expected configuration captured at frame start
  int e_len, e_ds, e_ts, e_ft;
  bit e_dsen, e_tsen, e_ndr;

  always #(CLK_PERIOD/2) clk = ~clk;

  slope_timing_gen dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .frame_start_i(frame_start), .line_tick_i(line_tick),
    .rst_len_i(rst_len), .ds_en_i(ds_en), .ds_pos_i(ds_pos), .ts_en_i(ts_en),
    .ts_pos_i(ts_pos), .xfer_pos_i(xfer_pos), .ndr_en_i(ndr_en),
    .pix_reset_o(pix_reset), .ds_reset_o(ds_reset), .ts_reset_o(ts_reset), .xfer_o(xfer)
  );

  task automatic check(input logic [3:0] act, input logic [3:0] exp, input string req, input int row);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s row %0d: {pix,ds,ts,xfer} actual %b expected %b", req, row, act, exp);
    end
  endtask

  function automatic logic [3:0] model(input int row);
    logic p, d, t, f;
    p = !e_ndr && row < ((e_len < 2) ? 2 : e_len) - 1;
    d = e_dsen && e_ds != 0 && row == e_ds - 1;
    t = e_tsen && e_ts != 0 && row == e_ts - 1;
    f = e_ft != 0 && row == e_ft - 1;
    return {p, d, t, f};
  endfunction

  task automatic set_cfg(input int len, input bit dse, input int dsp, input bit tse,
                         input int tsp, input int ftp, input bit ndr);
    rst_len = 12'(len); ds_en = dse; ds_pos = 12'(dsp); ts_en = tse;
    ts_pos = 12'(tsp); xfer_pos = 12'(ftp); ndr_en = ndr;
  endtask

  task automatic start_frame();
    @(negedge clk);
    frame_start = 1'b1;
    e_len = rst_len; e_ds = ds_pos; e_ts = ts_pos; e_ft = xfer_pos;
    e_dsen = ds_en; e_tsen = ts_en; e_ndr = ndr_en;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  // checks rows first..last, one tick per row plus an idle cycle
  task automatic run_rows(input int first, input int last, input string req);
    for (int r = first; r <= last; r++) begin
      check({pix_reset, ds_reset, ts_reset, xfer}, model(r > ROW_MAX ? ROW_MAX : r), req, r);
      line_tick = 1'b1;
      @(negedge clk);
      line_tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();  // R1
    check({pix_reset, ds_reset, ts_reset, xfer}, 4'b0000, "R1", -1);
    set_cfg(5, 1, 2, 1, 3, 4, 0);
    for (int i = 0; i < 6; i++) begin
      line_tick = 1'b1; @(negedge clk); line_tick = 1'b0; @(negedge clk);
      check({pix_reset, ds_reset, ts_reset, xfer}, 4'b0000, "R1", i);
    end
  endtask

  task automatic t_basic();  // R2 R3 R6
    set_cfg(5, 0, 0, 0, 0, 10, 0);
    start_frame();
    run_rows(0, 13, "R2/R3/R6");
  endtask

  task automatic t_slopes();  // R4 R5
    set_cfg(3, 1, 4, 1, 7, 9, 0);
    start_frame();
    run_rows(0, 11, "R4/R5");
    set_cfg(6, 1, 1, 1, 2, 3, 0);
    start_frame();
    run_rows(0, 8, "R4/R5");
  endtask

  task automatic t_disabled();  // R7
    set_cfg(2, 0, 3, 0, 5, 6, 0);
    start_frame();
    run_rows(0, 8, "R7");
  endtask

  task automatic t_min_len();  // R3
    set_cfg(0, 0, 0, 0, 0, 0, 0);
    start_frame();
    run_rows(0, 3, "R3");
    set_cfg(1, 0, 0, 0, 0, 0, 0);
    start_frame();
    run_rows(0, 3, "R3");
    set_cfg(2, 0, 0, 0, 0, 0, 0);
    start_frame();
    run_rows(0, 3, "R3");
  endtask

  task automatic t_pos_zero();  // R4 R6
    set_cfg(3, 1, 0, 1, 0, 0, 0);
    start_frame();
    run_rows(0, 6, "R4/R6");
  endtask

  task automatic t_ndr();  // R8
    set_cfg(6, 1, 3, 0, 0, 5, 1);
    start_frame();
    run_rows(0, 8, "R8");
  endtask

  task automatic t_midframe();  // R9
    set_cfg(4, 1, 5, 0, 0, 7, 0);
    start_frame();
    run_rows(0, 1, "R9");
    set_cfg(2, 0, 2, 1, 3, 4, 1);
    run_rows(2, 9, "R9");
    start_frame();
    run_rows(0, 6, "R9");
  endtask

  task automatic t_saturate();  // R10
    set_cfg(3, 1, 4095, 0, 0, 2, 0);
    start_frame();
    run_rows(0, ROW_MAX + 6, "R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_slopes();
    t_disabled();
    t_min_len();
    t_pos_zero();
    t_ndr();
    t_midframe();
    t_saturate();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule